// File: doc/BRIEF.md
# Two-Level Coherence Bridge Controller

This controller keeps coherence for one cache block at the middle node of a two-level, inclusive, full-map MSI hierarchy. Toward its children it behaves as a directory: it holds a lower-level state, a sharer bit-vector and an owner index, and it answers child requests and releases. Toward the root it behaves as a single cache with its own upper-level permission (I, S or M). When a child asks for more than the node's upper permission allows, the node first obtains that permission from the root and only then finishes the child's request. When the root demands the block back, or the node drops its own line, the node strips the children through an internal proxy cache. The proxy's request and its eviction are plain state updates and never leave the node.

The controller is atomic. It carries one transaction at a time. While a transaction is open it holds off new child requests and new root-forwarded requests by keeping their ready signals low. Nothing is dropped. All outgoing messages are single-cycle pulses. A multicast toward children names its targets in a bit mask.

Top module: `hier_dir_bridge`

## Requirements
- R1: After reset the lower state reads I (state encoding 0=I, 1=S, 2=M on `dir_state` and `up_state`), the sharer vector is zero, the upper state is I, no message pulse is issued, and `creq_ready` is high.
- R2: A child GetS (`creq_type` 0) while the upper state is I, or a child GetM (`creq_type` 1) while the upper state is not M, first emits GetS-up (`umsg_type` 0) or GetM-up (`umsg_type` 1). The upper state becomes S after a shared grant (`uin_type` 0) or M after an exclusive grant (`uin_type` 1). The child gets its data (`cmsg_type` 0 shared, 1 exclusive) only after that grant.
- R3: A child GetS that the upper permission already covers sends nothing upward. If no child owns the block, the requester gets shared data at once and joins the sharers. If another child owns it in M, the owner first gets a downgrade (`cmsg_type` 3) and answers on `crsp`, and then the requester gets shared data. Afterwards both children are sharers in S.
- R4: A child GetM, once the upper state is M, sends one invalidation (`cmsg_type` 2) whose mask holds every other holder. After all those children have answered, exclusive data goes to the requester. The lower state is then M with the requester as the only bit in the vector.
- R5: A child PutS (`creq_type` 2) clears that child's sharer bit, and the lower state falls to I when no sharer remains. A PutM (`creq_type` 3) from the owner sets the lower state to I and clears the vector, while the upper state stays M. Both are answered with a put-acknowledge (`cmsg_type` 4).
- R6: An upper invalidation (`uin_type` 2) makes the proxy take the block in M by invalidating every child holder and collecting their answers. The proxy then evicts, so the lower state reaches I. Only after that does the node send an invalidation-ack upward: `umsg_type` 5 (carrying data) when the upper state was M, 4 otherwise. The upper state then becomes I.
- R7: The proxy's own requests and evictions produce no child message. When no child holds the block, an upper invalidation or a self-eviction emits nothing on the child port, and every child message that is sent names at least one child.
- R8: An upper forwarded GetS (`uin_type` 3) downgrades a child owner in M (`cmsg_type` 3) and waits for its answer. The lower state then becomes S with that child kept as sharer, the upper state becomes S, and data goes upward (`umsg_type` 6).
- R9: A self-eviction request (`evict_req` while the upper state is not I) strips every child copy through the proxy. It then sends PutM-up (`umsg_type` 3) if the upper state is M, or PutS-up (`umsg_type` 2) if it is S, waits for the put-acknowledge (`uin_type` 4), and leaves the upper state at I.
- R10: While a transaction is open, `creq_ready` is low and forwarded root requests are not accepted. A waiting child request stays pending and is served afterwards. When idle, a forwarded root request wins over a simultaneous child request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| creq_valid | input | 1 | Child request present |
| creq_ready | output | 1 | Child request accepted this cycle |
| creq_type | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| creq_id | input | 2 | Requesting child index |
| crsp_valid | input | 1 | Child answer to an invalidation or downgrade |
| crsp_id | input | 2 | Answering child index |
| cmsg_valid | output | 1 | Child-bound message pulse |
| cmsg_type | output | 3 | 0 shared data, 1 exclusive data, 2 invalidate, 3 downgrade, 4 put-ack |
| cmsg_mask | output | 4 | Target children |
| uin_valid | input | 1 | Root message present |
| uin_ready | output | 1 | Root message accepted this cycle |
| uin_type | input | 3 | 0 shared grant, 1 exclusive grant, 2 invalidate, 3 forwarded GetS, 4 put-ack |
| umsg_valid | output | 1 | Root-bound message pulse |
| umsg_type | output | 3 | 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 inv-ack, 5 inv-ack with data, 6 data |
| evict_req | input | 1 | Request to drop the node's own line |
| dir_state | output | 2 | Lower-level directory state |
| up_state | output | 2 | Upper-level cache state |
| sharers | output | 4 | Child holder vector |

## Verification
One walk of child requests, root forwards and self-evictions takes the block through every pairing of lower and upper state. It shows apart child requests that need an upward fetch from those served locally, and GetS served directly from GetS that goes through an owner downgrade. It shows apart GetM that multicasts invalidations from an upgrade with no other holder, and inv-acks that carry data from those that do not. Evictions are tried with children holding the block and with none, which separates the proxy's silent work from real child traffic. Directed cases hold back a grant to show that a second child request waits rather than being lost, and present both kinds of request together to show the priority.

// File: rtl/hier_dir_bridge.sv
module hier_dir_bridge #(
  parameter int NCH = 4,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           creq_valid,
  output logic           creq_ready,
  input  logic [1:0]     creq_type,
  input  logic [IDW-1:0] creq_id,
  input  logic           crsp_valid,
  input  logic [IDW-1:0] crsp_id,
  output logic           cmsg_valid,
  output logic [2:0]     cmsg_type,
  output logic [NCH-1:0] cmsg_mask,
  input  logic           uin_valid,
  output logic           uin_ready,
  input  logic [2:0]     uin_type,
  output logic           umsg_valid,
  output logic [2:0]     umsg_type,
  input  logic           evict_req,
  output logic [1:0]     dir_state,
  output logic [1:0]     up_state,
  output logic [NCH-1:0] sharers
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] C_GETS = 2'd0, C_GETM = 2'd1, C_PUTS = 2'd2, C_PUTM = 2'd3;
  localparam logic [2:0] D_DATS = 3'd0, D_DATM = 3'd1, D_INV = 3'd2, D_DOWN = 3'd3, D_PACK = 3'd4;
  localparam logic [2:0] G_GRS = 3'd0, G_GRM = 3'd1, G_INV = 3'd2, G_FWDS = 3'd3, G_PACK = 3'd4;
  localparam logic [2:0] H_GETS = 3'd0, H_GETM = 3'd1, H_PUTS = 3'd2, H_PUTM = 3'd3,
                         H_IACK = 3'd4, H_IACKD = 3'd5, H_DATA = 3'd6;
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {IDLE, SERVE, WUP, WCH, FIN, PXEV, WPUT} st_t;
  typedef enum logic [2:0] {K_GS, K_GM, K_INV, K_FS, K_EV} kind_t;

  st_t            st;
  kind_t          kind;
  logic [IDW-1:0] rid, own;
  logic [NCH-1:0] pend;

  wire            idle     = (st == IDLE);
  wire            up_fwd   = uin_valid && (uin_type == G_INV || uin_type == G_FWDS);
  wire            up_grant = uin_valid && (uin_type == G_GRS || uin_type == G_GRM);
  wire            up_pack  = uin_valid && (uin_type == G_PACK);
  wire [NCH-1:0]  rid_mask = ONE << rid;
  wire [NCH-1:0]  own_mask = ONE << own;
  wire [NCH-1:0]  req_mask = ONE << creq_id;
  wire [NCH-1:0]  others   = sharers & ~rid_mask;
  wire [NCH-1:0]  pend_nx  = pend & ~(crsp_valid ? (ONE << crsp_id) : '0);
  wire [NCH-1:0]  puts_vec = sharers & ~req_mask;

  assign uin_ready  = (idle && up_fwd) || (st == WUP && up_grant) || (st == WPUT && up_pack);
  assign creq_ready = idle && !up_fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; kind <= K_GS; rid <= '0; own <= '0; pend <= '0;
      dir_state <= ST_I; up_state <= ST_I; sharers <= '0;
      cmsg_valid <= 1'b0; cmsg_type <= D_DATS; cmsg_mask <= '0;
      umsg_valid <= 1'b0; umsg_type <= H_GETS;
    end else begin
      cmsg_valid <= 1'b0;
      umsg_valid <= 1'b0;
      case (st)
        IDLE: begin
          if (uin_valid && uin_ready) begin
            kind <= (uin_type == G_INV) ? K_INV : K_FS;
            st   <= SERVE;
          end else if (creq_valid && creq_ready) begin
            rid <= creq_id;
            case (creq_type)
              C_GETS: begin
                kind <= K_GS;
                if (up_state == ST_I) begin
                  umsg_valid <= 1'b1; umsg_type <= H_GETS; st <= WUP;
                end else st <= SERVE;
              end
              C_GETM: begin
                kind <= K_GM;
                if (up_state != ST_M) begin
                  umsg_valid <= 1'b1; umsg_type <= H_GETM; st <= WUP;
                end else st <= SERVE;
              end
              C_PUTS: begin
                sharers <= puts_vec;
                if (dir_state == ST_S && puts_vec == '0) dir_state <= ST_I;
                cmsg_valid <= 1'b1; cmsg_type <= D_PACK; cmsg_mask <= req_mask;
              end
              default: begin
                if (dir_state == ST_M && own == creq_id) begin
                  dir_state <= ST_I; sharers <= '0;
                end
                cmsg_valid <= 1'b1; cmsg_type <= D_PACK; cmsg_mask <= req_mask;
              end
            endcase
          end else if (evict_req && up_state != ST_I) begin
            kind <= K_EV;
            st   <= SERVE;
          end
        end
        WUP: if (uin_valid && uin_ready) begin
          up_state <= (uin_type == G_GRM) ? ST_M : ST_S;
          st       <= SERVE;
        end
        SERVE: begin
          case (kind)
            K_GS: begin
              if (dir_state == ST_M && own != rid) begin
                cmsg_valid <= 1'b1; cmsg_type <= D_DOWN; cmsg_mask <= own_mask;
                pend <= own_mask; st <= WCH;
              end else begin
                cmsg_valid <= 1'b1; cmsg_type <= D_DATS; cmsg_mask <= rid_mask;
                sharers <= sharers | rid_mask; dir_state <= ST_S; st <= IDLE;
              end
            end
            K_GM: begin
              if (others != '0) begin
                cmsg_valid <= 1'b1; cmsg_type <= D_INV; cmsg_mask <= others;
                pend <= others; st <= WCH;
              end else st <= FIN;
            end
            K_FS: begin
              if (dir_state == ST_M && sharers != '0) begin
                cmsg_valid <= 1'b1; cmsg_type <= D_DOWN; cmsg_mask <= own_mask;
                pend <= own_mask; st <= WCH;
              end else st <= FIN;
            end
            default: begin
              if (sharers != '0) begin
                cmsg_valid <= 1'b1; cmsg_type <= D_INV; cmsg_mask <= sharers;
                pend <= sharers; st <= WCH;
              end else st <= FIN;
            end
          endcase
        end
        WCH: begin
          pend <= pend_nx;
          if (pend_nx == '0) st <= FIN;
        end
        FIN: begin
          case (kind)
            K_GS: begin
              dir_state <= ST_S; sharers <= sharers | rid_mask;
              cmsg_valid <= 1'b1; cmsg_type <= D_DATS; cmsg_mask <= rid_mask;
              st <= IDLE;
            end
            K_GM: begin
              dir_state <= ST_M; sharers <= rid_mask; own <= rid;
              cmsg_valid <= 1'b1; cmsg_type <= D_DATM; cmsg_mask <= rid_mask;
              st <= IDLE;
            end
            K_FS: begin
              if (dir_state == ST_M) dir_state <= ST_S;
              up_state <= ST_S;
              umsg_valid <= 1'b1; umsg_type <= H_DATA;
              st <= IDLE;
            end
            default: begin
              dir_state <= ST_M; sharers <= '0;
              st <= PXEV;
            end
          endcase
        end
        PXEV: begin
          dir_state  <= ST_I;
          umsg_valid <= 1'b1;
          if (kind == K_INV) begin
            umsg_type <= (up_state == ST_M) ? H_IACKD : H_IACK;
            up_state  <= ST_I;
            st        <= IDLE;
          end else begin
            umsg_type <= (up_state == ST_M) ? H_PUTM : H_PUTS;
            st        <= WPUT;
          end
        end
        WPUT: if (uin_valid && uin_ready) begin
          up_state <= ST_I;
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hier_dir_bridge_chk.sv
module hier_dir_bridge_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           creq_ready,
  input logic           uin_ready,
  input logic           uin_valid,
  input logic [2:0]     uin_type,
  input logic           cmsg_valid,
  input logic [2:0]     cmsg_type,
  input logic [NCH-1:0] cmsg_mask,
  input logic           umsg_valid,
  input logic [2:0]     umsg_type,
  input logic [1:0]     dir_state,
  input logic [1:0]     up_state,
  input logic [NCH-1:0] sharers
);
  AST_DATAS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmsg_valid && cmsg_type == 3'd0) |-> (up_state != 2'd0)); // R2
  AST_DATAM_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmsg_valid && cmsg_type == 3'd1) |-> (up_state == 2'd2)); // R2
  AST_M_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_state == 2'd2) |-> ($countones(sharers) <= 1)); // R4
  AST_DATAM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmsg_valid && cmsg_type == 3'd1) |-> ($countones(cmsg_mask) == 1)); // R4
  AST_DIR_I_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_state == 2'd0) |-> (sharers == '0)); // R5
  AST_INVACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (umsg_valid && (umsg_type == 3'd4 || umsg_type == 3'd5)) |-> (dir_state == 2'd0 && up_state == 2'd0)); // R6
  AST_CMSG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmsg_valid |-> (cmsg_mask != '0)); // R7
  AST_INCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_state != 2'd0) |-> (up_state != 2'd0)); // R9
  AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (umsg_valid && umsg_type <= 3'd1) |=> (!creq_ready && !(uin_ready && uin_valid && (uin_type == 3'd2 || uin_type == 3'd3)))); // R10
endmodule

bind hier_dir_bridge hier_dir_bridge_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .creq_ready(creq_ready), .uin_ready(uin_ready),
  .uin_valid(uin_valid), .uin_type(uin_type), .cmsg_valid(cmsg_valid),
  .cmsg_type(cmsg_type), .cmsg_mask(cmsg_mask), .umsg_valid(umsg_valid),
  .umsg_type(umsg_type), .dir_state(dir_state), .up_state(up_state), .sharers(sharers)
);

// File: tb/hier_dir_bridge_bench.sv
`timescale 1ns/1ps
module hier_dir_bridge_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, creq_valid, creq_ready, crsp_valid, cmsg_valid, uin_valid, uin_ready, umsg_valid, evict_req;
  logic [1:0] creq_type, creq_id, crsp_id, dir_state, up_state;
  logic [2:0] cmsg_type, uin_type, umsg_type;
  logic [3:0] cmsg_mask, sharers;

  hier_dir_bridge u_hier_dir_bridge (
    .clk(clk), .rst_n(rst_n), .creq_valid(creq_valid), .creq_ready(creq_ready),
    .creq_type(creq_type), .creq_id(creq_id), .crsp_valid(crsp_valid), .crsp_id(crsp_id),
    .cmsg_valid(cmsg_valid), .cmsg_type(cmsg_type), .cmsg_mask(cmsg_mask),
    .uin_valid(uin_valid), .uin_ready(uin_ready), .uin_type(uin_type),
    .umsg_valid(umsg_valid), .umsg_type(umsg_type), .evict_req(evict_req),
    .dir_state(dir_state), .up_state(up_state), .sharers(sharers));

  int n_chk = 0, n_bad = 0;
  int cmsg_cnt = 0, umsg_cnt = 0;
  int last_ct = 7, last_ut = 7;
  logic [3:0] resp_q = '0;
  int gp = 0;
  bit hold_grant = 0;
  bit s_creq_ready, s_uin_ready;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit acc_u, acc_c;
    #1;
    s_creq_ready = creq_ready;
    s_uin_ready  = uin_ready;
    acc_u = uin_valid && uin_ready;
    acc_c = creq_valid && creq_ready;
    @(negedge clk);
    if (cmsg_valid) begin
      cmsg_cnt++; last_ct = int'(cmsg_type);
      if (cmsg_type == 3'd2 || cmsg_type == 3'd3) resp_q |= cmsg_mask;
    end
    if (umsg_valid) begin
      umsg_cnt++; last_ut = int'(umsg_type);
      if (umsg_type == 3'd0) gp = 1;
      else if (umsg_type == 3'd1) gp = 2;
      else if (umsg_type == 3'd2 || umsg_type == 3'd3) gp = 3;
    end
    if (acc_c) creq_valid = 1'b0;
    if (acc_u) uin_valid = 1'b0;
    crsp_valid = 1'b0;
    if (resp_q != '0) begin
      for (int b = 3; b >= 0; b--) if (resp_q[b]) crsp_id = 2'(b);
      crsp_valid = 1'b1;
      resp_q[crsp_id] = 1'b0;
    end
    if (!uin_valid && gp != 0 && !hold_grant) begin
      uin_valid = 1'b1;
      uin_type  = (gp == 1) ? 3'd0 : (gp == 2) ? 3'd1 : 3'd4;
      gp = 0;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin step(); g++; end
    while (!(creq_ready && !creq_valid && !uin_valid && !crsp_valid && resp_q == '0 && gp == 0) && g < 200);
  endtask

  // op: 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 root Inv, 5 root fwd GetS, 6 evict
  // fields: op id dir shr up dcmsg dumsg last_cmsg last_umsg req (7 = no last-type check)
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0,2'd0,2'd1,4'b0001,2'd1,2'd1,2'd1,3'd0,3'd0,4'd2},  // R2 fetch S
    {3'd0,2'd2,2'd1,4'b0101,2'd1,2'd1,2'd0,3'd0,3'd7,4'd3},  // R3 local
    {3'd1,2'd1,2'd2,4'b0010,2'd2,2'd2,2'd1,3'd1,3'd1,4'd4},  // R4 multicast inv
    {3'd0,2'd3,2'd1,4'b1010,2'd2,2'd2,2'd0,3'd0,3'd7,4'd3},  // R3 via owner
    {3'd2,2'd3,2'd1,4'b0010,2'd2,2'd1,2'd0,3'd4,3'd7,4'd5},  // R5 PutS
    {3'd5,2'd0,2'd1,4'b0010,2'd1,2'd0,2'd1,3'd7,3'd6,4'd8},  // R8 no child owner
    {3'd4,2'd0,2'd0,4'b0000,2'd0,2'd1,2'd1,3'd2,3'd4,4'd6},  // R6 clean ack
    {3'd1,2'd2,2'd2,4'b0100,2'd2,2'd1,2'd1,3'd1,3'd1,4'd2},  // R2 fetch M
    {3'd5,2'd0,2'd1,4'b0100,2'd1,2'd1,2'd1,3'd3,3'd6,4'd8},  // R8 downgrade owner
    {3'd1,2'd2,2'd2,4'b0100,2'd2,2'd1,2'd1,3'd1,3'd1,4'd2},  // R2 upgrade
    {3'd4,2'd0,2'd0,4'b0000,2'd0,2'd1,2'd1,3'd2,3'd5,4'd6},  // R6 data ack
    {3'd0,2'd1,2'd1,4'b0010,2'd1,2'd1,2'd1,3'd0,3'd0,4'd2},  // R2
    {3'd6,2'd0,2'd0,4'b0000,2'd0,2'd1,2'd1,3'd2,3'd2,4'd9},  // R9 PutS-up
    {3'd1,2'd0,2'd2,4'b0001,2'd2,2'd1,2'd1,3'd1,3'd1,4'd2},  // R2
    {3'd3,2'd0,2'd0,4'b0000,2'd2,2'd1,2'd0,3'd4,3'd7,4'd5},  // R5 PutM
    {3'd6,2'd0,2'd0,4'b0000,2'd0,2'd0,2'd1,3'd7,3'd3,4'd7},  // R7 silent proxy
    {3'd1,2'd3,2'd2,4'b1000,2'd2,2'd1,2'd1,3'd1,3'd1,4'd4},  // R4
    {3'd6,2'd0,2'd0,4'b0000,2'd0,2'd1,2'd1,3'd2,3'd3,4'd9}   // R9 PutM-up
  };

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; creq_valid = 1'b0; creq_type = '0; creq_id = '0; crsp_valid = 1'b0;
    crsp_id = '0; uin_valid = 1'b0; uin_type = '0; evict_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk(dir_state == 2'd0, "R1", "dir_state", dir_state, 0);
    chk(sharers == 4'd0, "R1", "sharers", sharers, 0);
    chk(up_state == 2'd0, "R1", "up_state", up_state, 0);
    chk(cmsg_cnt == 0 && umsg_cnt == 0, "R1", "messages", cmsg_cnt + umsg_cnt, 0);
    chk(s_creq_ready == 1'b1, "R1", "creq_ready", s_creq_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      int c0, u0;
      v = VEC[i];
      c0 = cmsg_cnt; u0 = umsg_cnt;
      last_ct = 7; last_ut = 7;
      if (v[26:24] <= 3'd3) begin
        creq_type = v[25:24]; creq_id = v[23:22]; creq_valid = 1'b1;
        wait_idle();
      end else if (v[26:24] == 3'd4 || v[26:24] == 3'd5) begin
        uin_type = (v[26:24] == 3'd4) ? 3'd2 : 3'd3; uin_valid = 1'b1;
        wait_idle();
      end else begin
        evict_req = 1'b1; step(); evict_req = 1'b0;
        wait_idle();
      end
      chk(dir_state == v[21:20], $sformatf("R%0d vec%0d", v[3:0], i), "dir_state", dir_state, v[21:20]);
      chk(sharers == v[19:16], $sformatf("R%0d vec%0d", v[3:0], i), "sharers", sharers, v[19:16]);
      chk(up_state == v[15:14], $sformatf("R%0d vec%0d", v[3:0], i), "up_state", up_state, v[15:14]);
      chk(cmsg_cnt - c0 == int'(v[13:12]), $sformatf("R%0d vec%0d", v[3:0], i), "child msgs", cmsg_cnt - c0, v[13:12]);
      chk(umsg_cnt - u0 == int'(v[11:10]), $sformatf("R%0d vec%0d", v[3:0], i), "root msgs", umsg_cnt - u0, v[11:10]);
      if (v[9:7] != 3'd7)
        chk(last_ct == int'(v[9:7]), $sformatf("R%0d vec%0d", v[3:0], i), "last child type", last_ct, v[9:7]);
      if (v[6:4] != 3'd7)
        chk(last_ut == int'(v[6:4]), $sformatf("R%0d vec%0d", v[3:0], i), "last root type", last_ut, v[6:4]);
    end

    // R10: second child request waits while the grant is held back
    begin
      int c0, u0;
      c0 = cmsg_cnt; u0 = umsg_cnt;
      hold_grant = 1;
      creq_type = 2'd0; creq_id = 2'd0; creq_valid = 1'b1;
      step();
      creq_type = 2'd0; creq_id = 2'd1; creq_valid = 1'b1;
      repeat (4) step();
      chk(s_creq_ready == 1'b0, "R10", "creq_ready while open", s_creq_ready, 0);
      chk(creq_valid == 1'b1, "R10", "second request pending", creq_valid, 1);
      chk(cmsg_cnt == c0, "R10", "child msgs before grant", cmsg_cnt - c0, 0);
      hold_grant = 0;
      wait_idle();
      chk(sharers == 4'b0011, "R10", "both served", sharers, 3);
      chk(umsg_cnt - u0 == 1, "R10", "one upward fetch", umsg_cnt - u0, 1);
      chk(up_state == 2'd1, "R2", "up_state after grant", up_state, 1);
    end

    // R10: root forward wins over a child request presented together
    creq_type = 2'd0; creq_id = 2'd2; creq_valid = 1'b1;
    uin_type = 3'd3; uin_valid = 1'b1;
    step();
    chk(s_creq_ready == 1'b0, "R10", "child ready under root forward", s_creq_ready, 0);
    chk(s_uin_ready == 1'b1, "R10", "root forward ready", s_uin_ready, 1);
    wait_idle();
    chk(sharers == 4'b0111, "R10", "child served after forward", sharers, 7);
    chk(last_ct == 0, "R3", "shared data last", last_ct, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule